// File: doc/BRIEF.md
# Memory Operand Address Resolver

This block turns the three 16-bit memory operand fields of an instruction into word addresses for a 1024-word, 32-bit data memory. It then fetches the two source values through a synchronous single-port read interface. Each field names a base word and a small signed offset, and carries a flag that says whether the base word is used directly or first read as a pointer. A pointer read adds one dependent memory access before the real operand can be fetched. Word 0 acts as a zero register: it always reads as zero.

An execute stage raises `start` for one cycle with the operand bits of the instruction register and a skip mask for operands the opcode does not use. When `done` pulses, the stage receives the first and third operands' values on `src_a` and `src_b` and the second operand's effective address on `dst_addr`. The resolver holds these results until the next accepted `start`. It issues one read at a time, and every read is followed by one cycle in which the returned word is consumed.

Top module: `opnd_resolver`

## Requirements
- R1: `instr_lo` carries operand 1 in bits [47:32], operand 2 in [31:16] and operand 3 in [15:0]. Within a field, bits [15:6] are the base A, bits [5:1] are the offset F and bit [0] is the indirect flag. With the flag at 0, the source result is memory word A (operand 1 on `src_a`, operand 3 on `src_b`).
- R2: With the flag at 1, word A is read as a pointer. The effective address is (pointer[9:0] + F sign-extended from 5 bits) modulo 1024, so offsets from -16 to +15 wrap around the word space.
- R3: Any read whose address is 0 yields 0, both for pointer reads and for data reads, whatever the memory returns.
- R4: Operand 2 is a destination. When direct, `dst_addr` is A and no read is issued for it. When indirect, one pointer read is issued and `dst_addr` is the effective address from R2, with no data read.
- R5: Reads are issued in operand order 1, 3, 2. `mem_rd_en` is never high in two consecutive cycles. The read for a pointer comes right before the data read it feeds.
- R6: `done` is high exactly one cycle. It rises N clock edges after the edge that accepts `start`, where N sums 2 per direct source, 4 per indirect source, 2 for an indirect destination and 0 for a direct or skipped one.
- R7: In `skip_mask`, bit 0 skips operand 1, bit 1 skips operand 2 and bit 2 skips operand 3. A skipped operand issues no read, and its output is 0.
- R8: `src_a`, `src_b` and `dst_addr` stay unchanged from `done` until the next accepted `start`. A `start` that arrives while a resolution is in progress is ignored.
- R9: After reset, `done`, `mem_rd_en`, `src_a`, `src_b` and `dst_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving; sampled only while idle |
| instr_lo | input | 48 | Low 48 bits of the instruction: three operand fields |
| skip_mask | input | 3 | Per-operand skip (bit0 op1, bit1 op2, bit2 op3) |
| mem_rd_en | output | 1 | Read request to data memory |
| mem_rd_addr | output | 10 | Word address of the read |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| src_a | output | 32 | Value of operand 1 |
| src_b | output | 32 | Value of operand 3 |
| dst_addr | output | 10 | Effective address of operand 2 |
| done | output | 1 | One-cycle pulse when results are ready |

## Verification
The assertions assume that the memory returns the addressed word exactly one cycle after a request, and that `start` is a single-cycle strobe. The bench memory model is a synchronous array that meets the first assumption. The bench raises `start` for exactly one cycle per transaction, except for one deliberate extra strobe in the middle of a busy resolution. Pointer words are preloaded so that the cases reach a negative offset, wrap past both ends of the address space, have upper pointer bits set, and land on word 0 as a nonzero stored value.

// File: rtl/opres_pkg.sv
package opres_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_PTRW,
    ST_DAT,
    ST_DATW
  } opres_state_e;

  // resolution order position -> operand index (0 = op1, 1 = op2, 2 = op3)
  function automatic logic [1:0] order_op(input logic [1:0] pos);
    case (pos)
      2'd0:    order_op = 2'd0;
      2'd1:    order_op = 2'd2;
      default: order_op = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/opres_field_split.sv
module opres_field_split #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 5,
  localparam int FIELD_W = ADDR_W + OFF_W + 1
) (
  input  logic [FIELD_W-1:0] fld,
  output logic [ADDR_W-1:0]  base,
  output logic [OFF_W-1:0]   offs,
  output logic               ind
);
  assign base = fld[FIELD_W-1 -: ADDR_W];
  assign offs = fld[OFF_W:1];
  assign ind  = fld[0];
endmodule

// File: rtl/opres_ea_calc.sv
module opres_ea_calc #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 5
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [OFF_W-1:0]  offs,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - OFF_W;
  logic [ADDR_W-1:0] offs_ext;
  assign offs_ext = {{EXT_W{offs[OFF_W-1]}}, offs};
  assign ea = ptr + offs_ext;   // wraps modulo 2**ADDR_W
endmodule

// File: rtl/opres_ctrl.sv
module opres_ctrl
  import opres_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [2:0]                  skip_i,
  input  logic [2:0][ADDR_W-1:0]      base_i,
  input  logic [2:0][OFF_W-1:0]       offs_i,
  input  logic [2:0]                  ind_i,
  output logic                        rd_en,
  output logic [ADDR_W-1:0]           rd_addr,
  input  logic [DATA_W-1:0]           rd_data,
  output logic [DATA_W-1:0]           src_a,
  output logic [DATA_W-1:0]           src_b,
  output logic [ADDR_W-1:0]           dst,
  output logic                        done
);
  opres_state_e              state_q;
  logic [1:0]                pos_q;
  logic [2:0][ADDR_W-1:0]    base_q;
  logic [2:0][OFF_W-1:0]     offs_q;
  logic [2:0]                ind_q;
  logic [2:0]                act_q;
  logic                      zflag_q;
  logic                      rd_en_q;
  logic [ADDR_W-1:0]         rd_addr_q;
  logic [DATA_W-1:0]         src_a_q, src_b_q;
  logic [ADDR_W-1:0]         dst_q;
  logic                      done_q;

  // selection of the next operand that needs memory work
  logic                      idle;
  logic [2:0]                act_c, ind_c;
  logic [2:0][ADDR_W-1:0]    base_c;
  logic [2:0]                from_pos, nxt_pos;
  logic [1:0]                scan_op, nxt_op, cur_op;

  assign idle   = (state_q == ST_IDLE);
  assign cur_op = order_op(pos_q);

  always_comb begin
    act_c    = idle ? ~skip_i : act_q;
    ind_c    = idle ? ind_i   : ind_q;
    base_c   = idle ? base_i  : base_q;
    from_pos = idle ? 3'd0 : ({1'b0, pos_q} + 3'd1);
    nxt_pos  = 3'd3;
    scan_op  = 2'd0;
    for (int p = 2; p >= 0; p--) begin
      scan_op = order_op(2'(p));
      if ((3'(p) >= from_pos) && act_c[scan_op] && ((scan_op != 2'd1) || ind_c[scan_op]))
        nxt_pos = 3'(p);
    end
    nxt_op = order_op(nxt_pos[1:0]);
  end

  // pointer arithmetic on the returned word
  logic [DATA_W-1:0] rd_val;
  logic [ADDR_W-1:0] ea;
  assign rd_val = zflag_q ? '0 : rd_data;

  opres_ea_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ea (
    .ptr  (rd_val[ADDR_W-1:0]),
    .offs (offs_q[cur_op]),
    .ea   (ea)
  );

  logic enter;
  always_comb begin
    enter = 1'b0;
    case (state_q)
      ST_IDLE: enter = start;
      ST_PTRW: enter = (cur_op == 2'd1);
      ST_DATW: enter = 1'b1;
      default: enter = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pos_q     <= 2'd0;
      base_q    <= '0;
      offs_q    <= '0;
      ind_q     <= '0;
      act_q     <= '0;
      zflag_q   <= 1'b0;
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
      src_a_q   <= '0;
      src_b_q   <= '0;
      dst_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      rd_en_q <= 1'b0;
      done_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          base_q  <= base_i;
          offs_q  <= offs_i;
          ind_q   <= ind_i;
          act_q   <= ~skip_i;
          src_a_q <= '0;
          src_b_q <= '0;
          dst_q   <= (!skip_i[1] && !ind_i[1]) ? base_i[1] : '0;
        end
        ST_PTR: state_q <= ST_PTRW;
        ST_PTRW: begin
          if (cur_op == 2'd1) begin
            dst_q <= ea;
          end else begin
            state_q   <= ST_DAT;
            rd_en_q   <= 1'b1;
            rd_addr_q <= ea;
            zflag_q   <= (ea == '0);
          end
        end
        ST_DAT: state_q <= ST_DATW;
        ST_DATW: begin
          if (cur_op == 2'd0) src_a_q <= rd_val;
          else                src_b_q <= rd_val;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (enter) begin
        if (nxt_pos == 3'd3) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          pos_q     <= nxt_pos[1:0];
          state_q   <= ind_c[nxt_op] ? ST_PTR : ST_DAT;
          rd_en_q   <= 1'b1;
          rd_addr_q <= base_c[nxt_op];
          zflag_q   <= (base_c[nxt_op] == '0);
        end
      end
    end
  end

  assign rd_en   = rd_en_q;
  assign rd_addr = rd_addr_q;
  assign src_a   = src_a_q;
  assign src_b   = src_b_q;
  assign dst     = dst_q;
  assign done    = done_q;

  // R6: completion is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5: each read is followed by a cycle without a request
  p_read_gap_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |=> !rd_en_q);

  // R5: a request is only outstanding in an issue state
  p_read_state_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |-> (state_q == ST_PTR || state_q == ST_DAT));

  // R8: results are held while idle without a new start
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (idle && !start) |=> ($stable(src_a_q) && $stable(src_b_q) && $stable(dst_q)));

  // R3: a data read of word 0 captures zero into operand 1's result
  p_zero_word_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATW && zflag_q && cur_op == 2'd0) |=> (src_a_q == '0));

  // R8: a start seen while busy does not restart the sequence
  p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PTR && start) |=> (state_q == ST_PTRW));
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 5,
  localparam int FIELD_W = ADDR_W + OFF_W + 1,
  localparam int NOPS    = 3,
  localparam int OPBITS  = NOPS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OPBITS-1:0] instr_lo,
  input  logic [NOPS-1:0]   skip_mask,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic [DATA_W-1:0] src_a,
  output logic [DATA_W-1:0] src_b,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              done
);
  logic [NOPS-1:0][ADDR_W-1:0] base;
  logic [NOPS-1:0][OFF_W-1:0]  offs;
  logic [NOPS-1:0]             ind;

  // operand k (0 = op1) sits at the most significant end, op3 at the bottom
  for (genvar k = 0; k < NOPS; k++) begin : g_field
    opres_field_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_split (
      .fld  (instr_lo[(NOPS-k)*FIELD_W-1 -: FIELD_W]),
      .base (base[k]),
      .offs (offs[k]),
      .ind  (ind[k])
    );
  end

  opres_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .skip_i  (skip_mask),
    .base_i  (base),
    .offs_i  (offs),
    .ind_i   (ind),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_rd_addr),
    .rd_data (mem_rd_data),
    .src_a   (src_a),
    .src_b   (src_b),
    .dst     (dst_addr),
    .done    (done)
  );
endmodule

// File: tb/sim_opnd_resolver.sv
module sim_opnd_resolver;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [47:0] instr_lo = '0;
  logic [2:0]  skip_mask = '0;
  logic        mem_rd_en;
  logic [9:0]  mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic [31:0] src_a, src_b;
  logic [9:0]  dst_addr;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [31:0] mem [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
  end

  opnd_resolver u0 (
    .clk(clk), .rst(rst), .start(start), .instr_lo(instr_lo),
    .skip_mask(skip_mask), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .src_a(src_a), .src_b(src_b),
    .dst_addr(dst_addr), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] fld(input int a, input int f, input bit x);
    return {a[9:0], f[4:0], x};
  endfunction

  function automatic logic [31:0] rd_word(input int a);
    return (a == 0) ? 32'd0 : mem[a];
  endfunction

  function automatic int ea_of(input logic [15:0] f);
    int a, off, ptr;
    a   = int'(f[15:6]);
    off = f[5] ? int'(f[5:1]) - 32 : int'(f[5:1]);
    if (!f[0]) return a;
    ptr = int'(rd_word(a) & 32'h3FF);
    return (ptr + off + 1024) % 1024;
  endfunction

  // reference: expected request trace (one entry per cycle) and results
  task automatic run(input logic [47:0] ins, input logic [2:0] skp, input bit poke, input string tag);
    logic [10:0] trace[$];
    logic [15:0] f;
    int op;
    logic [31:0] ea, xa, xb;
    logic [9:0]  xd;
    int order[3] = '{0, 2, 1};
    xa = 0; xb = 0; xd = 0;
    for (int i = 0; i < 3; i++) begin
      op = order[i];
      f  = ins[(3-op)*16-1 -: 16];
      if (skp[op]) continue;
      if (f[0]) begin
        trace.push_back({1'b1, f[15:6]});
        trace.push_back(11'd0);
      end
      ea = 32'(ea_of(f));
      if (op == 1) xd = ea[9:0];
      else begin
        trace.push_back({1'b1, ea[9:0]});
        trace.push_back(11'd0);
        if (op == 0) xa = rd_word(int'(ea)); else xb = rd_word(int'(ea));
      end
    end
    @(negedge clk);
    instr_lo = ins; skip_mask = skp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < trace.size(); i++) begin
      if (poke && i == 0) begin start = 1'b1; instr_lo = ~ins; skip_mask = 3'b000; end
      if (poke && i == 1) start = 1'b0;
      // R5: request trace, order 1,3,2 with a gap after each read; R6: no early done
      chk({mem_rd_en, mem_rd_en ? mem_rd_addr : 10'd0} == trace[i] && !done,
          {"R5/R6 ", tag}, {done, mem_rd_en, mem_rd_addr}, {1'b0, trace[i]});
      @(negedge clk);
    end
    // R6: done after the expected number of edges
    chk(done === 1'b1, {"R6 done ", tag}, done, 1);
    // R1 R2 R3 R4 R7: results
    chk(src_a === xa, {"R1/R2/R3/R7 src_a ", tag}, src_a, xa);
    chk(src_b === xb, {"R1/R2/R3/R7 src_b ", tag}, src_b, xb);
    chk(dst_addr === xd, {"R4/R7 dst_addr ", tag}, dst_addr, xd);
    @(negedge clk);
    chk(done === 1'b0, {"R6 pulse ", tag}, done, 0);
    repeat (2) @(negedge clk);
    // R8: held until the next start
    chk(src_a === xa && src_b === xb && dst_addr === xd && !mem_rd_en,
        {"R8 hold ", tag}, {src_a, src_b}, {xa, xb});
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (32'(i) * 32'h0101_0101) ^ 32'hA5A5_0000;
    mem[0]  = 32'hDEAD_BEEF;
    mem[40] = 32'd100;
    mem[41] = 32'hFFFF_F3FC;   // low 10 bits = 1020
    mem[42] = 32'd3;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!done && !mem_rd_en && src_a == 0 && src_b == 0 && dst_addr == 0, "R9 reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !mem_rd_en, "R9 after release", {done, mem_rd_en}, 0);

    // R1: all direct
    run({fld(5,0,0), fld(9,0,0), fld(7,0,0)}, 3'b000, 1'b0, "direct");
    // R2 R4 R8: all indirect, positive offsets, extra start while busy ignored
    run({fld(40,3,1), fld(40,0,1), fld(42,15,1)}, 3'b000, 1'b1, "indirect");
    // R2 R3: negative offsets, wrap past 1023, result landing on word 0
    run({fld(40,-16,1), fld(41,15,1), fld(42,-3,1)}, 3'b000, 1'b0, "negative");
    // R3: direct read of word 0, pointer from word 0 wrapping below zero
    run({fld(0,0,0), fld(0,-2,1), fld(0,-1,1)}, 3'b000, 1'b0, "zero");
    // R7: skip op2 and op3
    run({fld(41,-4,1), fld(9,0,0), fld(7,0,0)}, 3'b110, 1'b0, "skip23");
    // R7: skip op1, direct destination
    run({fld(5,0,0), fld(33,0,0), fld(12,0,0)}, 3'b001, 1'b0, "skip1");
    // R6 R7: everything skipped, done on the accepting edge
    run({fld(5,0,0), fld(9,0,0), fld(7,0,0)}, 3'b111, 1'b0, "skipall");
    // R4: direct destination with indirect sources
    run({fld(42,1,1), fld(77,0,0), fld(40,-1,1)}, 3'b000, 1'b0, "mixed");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule